// File: doc/BRIEF.md
# Coprocessor Two-Beat Load/Store Sequencer

This block moves data between a 32-bit memory data port and a file of sixteen 64-bit coprocessor registers. Each register has an upper and a lower 32-bit half. A transfer is one or two data beats. The instruction word supplies the register index and the transfer length. A separate setup strobe stands for any non-data phase: it returns the beat counter to zero and finishes at once.

A long transfer moves both halves, one per beat. The endianness input decides which half goes first. A short transfer moves a single word, and the format input controls where that word goes. For float format the word always uses the upper half. For integer format, a load fills the whole register with the sign-extended word, and a store returns the lower half.

After the first beat of a long transfer the block pulses an increment request, so the address source can step to the next word. At the end of every transfer it pulses done. Load data is written at the clock edge that ends the beat. Store data is presented combinationally during the beat.

Top module: `cp_beat_seq`

## Requirements
- R1: After reset every register of the file reads as zero and both `inc_o` and `done_o` are low.
- R2: Bits 15:12 of `instr_i` select the register. Bit 22 set means a long (two-beat) transfer; bit 22 clear means a short (one-beat) transfer.
- R3: On a long load with `big_endian_i`=1, the first beat's word goes to the upper half and the second beat's word goes to the lower half. With `big_endian_i`=0 the order is lower then upper.
- R4: A long store presents the halves on `rdata_o` in the same endianness-dependent order as R3.
- R5: After the first beat of a long transfer, `inc_o` is high for exactly the next cycle and `done_o` stays low. After the second beat, `done_o` is high for exactly the next cycle.
- R6: A cycle with `setup_i` high returns the beat counter to zero and raises `done_o` in the next cycle without `inc_o`. It takes priority over a beat in the same cycle, and that beat writes nothing.
- R7: A short load in float format (`fmt_int_i`=0) writes the word into the upper half and leaves the lower half unchanged.
- R8: A short load in integer format (`fmt_int_i`=1) writes the word into the lower half and fills the upper half with copies of bit 31 of the word.
- R9: A short store returns the upper half in float format and the lower half in integer format. It raises `done_o` in the next cycle.
- R10: A write to one half never alters the other half, and a long transfer ignores `fmt_int_i`.
- R11: `inc_o` and `done_o` are never high in the same cycle. Each is high only in the cycle after a beat or a setup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| setup_i | input | 1 | Non-data phase: clears the beat counter and completes |
| beat_i | input | 1 | A data beat is presented this cycle |
| store_i | input | 1 | 1 = store (register to memory), 0 = load |
| instr_i | input | 32 | Instruction word: index in bits 15:12, long flag in bit 22 |
| big_endian_i | input | 1 | 1 = upper half moves first on long transfers |
| fmt_int_i | input | 1 | 1 = integer format, 0 = float format (short transfers only) |
| wdata_i | input | 32 | Load data word |
| rdata_o | output | 32 | Store data word for the current beat |
| inc_o | output | 1 | Pulse: step to the next word |
| done_o | output | 1 | Pulse: transfer complete |

## Verification
The hardest case to reach from the ports is a long transfer cut off after its first beat. The block then holds a half-written register and a beat counter at one. Only a setup strobe can bring the counter back to zero, and the next long transfer must start again at its first half. The stimulus reaches this case on purpose: it issues a lone first beat, sometimes with a setup and a beat in the same cycle, and then a full long transfer. It reads the register back through long stores to confirm both the half order and that the untouched half kept its value. Random sequences then mix lengths, formats, endianness and directions against a bench model of the file.

// File: rtl/cp_seq_pkg.sv
package cp_seq_pkg;
  typedef enum logic [1:0] {
    SEL_LO   = 2'd0,
    SEL_HI   = 2'd1,
    SEL_BOTH = 2'd2
  } half_sel_e;
endpackage

// File: rtl/cp_half_map.sv
module cp_half_map
  import cp_seq_pkg::*;
(
  input  logic      long_i,
  input  logic      beat_idx_i,
  input  logic      big_endian_i,
  input  logic      fmt_int_i,
  input  logic      store_i,
  output half_sel_e sel_o
);
  logic hi_first;

  always_comb begin
    // big endian: first beat -> upper half; little endian: first beat -> lower half
    hi_first = (beat_idx_i == 1'b0) ? big_endian_i : !big_endian_i;
    if (long_i)         sel_o = hi_first ? SEL_HI : SEL_LO;
    else if (!fmt_int_i) sel_o = SEL_HI;
    else if (store_i)   sel_o = SEL_LO;
    else                sel_o = SEL_BOTH;
  end
endmodule

// File: rtl/cp_reg_file.sv
module cp_reg_file #(
  parameter int unsigned NREG   = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_lo_i,
  input  logic              we_hi_i,
  input  logic [WORD_W-1:0] wlo_i,
  input  logic [WORD_W-1:0] whi_i,
  output logic [WORD_W-1:0] rlo_o,
  output logic [WORD_W-1:0] rhi_o
);
  logic [WORD_W-1:0] lo_q [NREG];
  logic [WORD_W-1:0] hi_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q[g] <= '0;
        hi_q[g] <= '0;
      end else if (idx_i == IDX_W'(g)) begin
        if (we_lo_i) lo_q[g] <= wlo_i;
        if (we_hi_i) hi_q[g] <= whi_i;
      end
    end
  end

  assign rlo_o = lo_q[idx_i];
  assign rhi_o = hi_q[idx_i];
endmodule

// File: rtl/cp_beat_ctrl.sv
module cp_beat_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic setup_i,
  input  logic beat_i,
  input  logic long_i,
  output logic beat_idx_o,
  output logic inc_o,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_idx_o <= 1'b0;
      inc_o      <= 1'b0;
      done_o     <= 1'b0;
    end else if (setup_i) begin
      beat_idx_o <= 1'b0;
      inc_o      <= 1'b0;
      done_o     <= 1'b1;
    end else if (beat_i) begin
      if (long_i && !beat_idx_o) begin
        beat_idx_o <= 1'b1;
        inc_o      <= 1'b1;
        done_o     <= 1'b0;
      end else begin
        beat_idx_o <= 1'b0;
        inc_o      <= 1'b0;
        done_o     <= 1'b1;
      end
    end else begin
      inc_o  <= 1'b0;
      done_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cp_beat_seq.sv
module cp_beat_seq
  import cp_seq_pkg::*;
#(
  parameter int unsigned NREG     = 16,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned INSTR_W  = 32,
  parameter int unsigned IDX_LSB  = 12,
  parameter int unsigned LONG_BIT = 22,
  localparam int unsigned IDX_W   = $clog2(NREG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               setup_i,
  input  logic               beat_i,
  input  logic               store_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               big_endian_i,
  input  logic               fmt_int_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               inc_o,
  output logic               done_o
);
  logic [IDX_W-1:0]  idx;
  logic              is_long, beat_idx, do_load;
  half_sel_e         sel;
  logic              we_lo, we_hi;
  logic [WORD_W-1:0] whi, rlo, rhi;

  assign idx     = instr_i[IDX_LSB +: IDX_W];
  assign is_long = instr_i[LONG_BIT];

  cp_beat_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .setup_i    (setup_i),
    .beat_i     (beat_i),
    .long_i     (is_long),
    .beat_idx_o (beat_idx),
    .inc_o      (inc_o),
    .done_o     (done_o)
  );

  cp_half_map u_map (
    .long_i       (is_long),
    .beat_idx_i   (beat_idx),
    .big_endian_i (big_endian_i),
    .fmt_int_i    (fmt_int_i),
    .store_i      (store_i),
    .sel_o        (sel)
  );

  // setup has priority: a beat in the same cycle is dropped
  assign do_load = beat_i && !setup_i && !store_i;
  assign we_lo   = do_load && (sel == SEL_LO || sel == SEL_BOTH);
  assign we_hi   = do_load && (sel == SEL_HI || sel == SEL_BOTH);
  assign whi     = (sel == SEL_BOTH) ? {WORD_W{wdata_i[WORD_W-1]}} : wdata_i;

  cp_reg_file #(.NREG(NREG), .WORD_W(WORD_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (idx),
    .we_lo_i (we_lo),
    .we_hi_i (we_hi),
    .wlo_i   (wdata_i),
    .whi_i   (whi),
    .rlo_o   (rlo),
    .rhi_o   (rhi)
  );

  assign rdata_o = (sel == SEL_HI) ? rhi : rlo;
endmodule

// File: rtl/cp_beat_seq_chk.sv
module cp_beat_seq_chk #(
  parameter int unsigned INSTR_W  = 32,
  parameter int unsigned LONG_BIT = 22
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               setup_i,
  input logic               beat_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic               inc_o,
  input logic               done_o
);
  AST_PULSE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inc_o && done_o)); // R11
  AST_SETUP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_i |=> (done_o && !inc_o)); // R6
  AST_SHORT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !setup_i && !instr_i[LONG_BIT]) |=> done_o); // R9
  AST_SECOND_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_o && beat_i && !setup_i && instr_i[LONG_BIT]) |=> (done_o && !inc_o)); // R5
  AST_INC_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> $past(beat_i && !setup_i && instr_i[LONG_BIT])); // R11
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(beat_i || setup_i)); // R11
endmodule

bind cp_beat_seq cp_beat_seq_chk #(.INSTR_W(INSTR_W), .LONG_BIT(LONG_BIT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .setup_i (setup_i),
  .beat_i  (beat_i),
  .instr_i (instr_i),
  .inc_o   (inc_o),
  .done_o  (done_o)
);

// File: tb/sim_cp_beat_seq.sv
`timescale 1ns/1ps
module sim_cp_beat_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        setup = 1'b0, beat = 1'b0, store = 1'b0, be = 1'b0, fint = 1'b0;
  logic [31:0] instr = '0, wdata = '0;
  logic [31:0] rdata;
  logic        inc, done;
  int          n_chk = 0, n_bad = 0;
  logic [63:0] mdl [16];

  always #2.5 clk = ~clk;

  cp_beat_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .setup_i(setup), .beat_i(beat), .store_i(store),
    .instr_i(instr), .big_endian_i(be), .fmt_int_i(fint), .wdata_i(wdata),
    .rdata_o(rdata), .inc_o(inc), .done_o(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_instr(input logic [3:0] idx, input logic lng);
    logic [31:0] r = $urandom();
    r[15:12] = idx;
    r[22]    = lng;
    return r;
  endfunction

  // one beat; returns rdata seen during the beat and the pulses seen afterwards
  task automatic do_beat(input logic st, input logic [31:0] ins, input logic [31:0] wd,
                         input logic su, output logic [31:0] rd, output logic [1:0] pulses);
    @(negedge clk);
    beat = 1'b1; store = st; instr = ins; wdata = wd; setup = su;
    #1 rd = rdata;
    @(posedge clk);
    #0.5 beat = 1'b0; setup = 1'b0;
    @(negedge clk);
    pulses = {inc, done};
  endtask

  task automatic do_setup(input string req);
    logic [31:0] rd; logic [1:0] p;
    @(negedge clk); setup = 1'b1;
    @(posedge clk); #0.5 setup = 1'b0;
    @(negedge clk); p = {inc, done};
    chk(req, 64'(p), 64'b01);
    rd = '0;
  endtask

  function automatic logic first_hi(input logic b); return b; endfunction

  task automatic long_load(input logic [3:0] idx, input logic [31:0] w0, input logic [31:0] w1);
    logic [31:0] rd; logic [1:0] p; logic [31:0] ins = mk_instr(idx, 1'b1);
    do_beat(1'b0, ins, w0, 1'b0, rd, p);
    chk("R5 inc after first beat", 64'(p), 64'b10);
    if (first_hi(be)) mdl[idx][63:32] = w0; else mdl[idx][31:0] = w0;
    do_beat(1'b0, ins, w1, 1'b0, rd, p);
    chk("R5 done after second beat", 64'(p), 64'b01);
    if (first_hi(be)) mdl[idx][31:0] = w1; else mdl[idx][63:32] = w1;
  endtask

  task automatic long_store(input logic [3:0] idx, input string req);
    logic [31:0] r0, r1; logic [1:0] p; logic [31:0] ins = mk_instr(idx, 1'b1);
    do_beat(1'b1, ins, $urandom(), 1'b0, r0, p);
    chk("R5 store inc", 64'(p), 64'b10);
    do_beat(1'b1, ins, $urandom(), 1'b0, r1, p);
    chk("R5 store done", 64'(p), 64'b01);
    if (first_hi(be)) chk(req, {r0, r1}, mdl[idx]);
    else              chk(req, {r1, r0}, mdl[idx]);
  endtask

  task automatic short_load(input logic [3:0] idx, input logic [31:0] w);
    logic [31:0] rd; logic [1:0] p;
    do_beat(1'b0, mk_instr(idx, 1'b0), w, 1'b0, rd, p);
    chk("R9 short load done", 64'(p), 64'b01);
    if (fint) mdl[idx] = {{32{w[31]}}, w};
    else      mdl[idx][63:32] = w;
  endtask

  task automatic short_store(input logic [3:0] idx);
    logic [31:0] rd; logic [1:0] p;
    do_beat(1'b1, mk_instr(idx, 1'b0), $urandom(), 1'b0, rd, p);
    chk("R9 short store done", 64'(p), 64'b01);
    chk("R9 short store data", 64'(rd), fint ? 64'(mdl[idx][31:0]) : 64'(mdl[idx][63:32]));
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic [1:0] p;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulses low after reset", 64'({inc, done}), 64'b00);
    be = 1'b1;
    for (int i = 0; i < 16; i++) long_store(4'(i), "R1 reset zero");

    // R3 R4 big endian, R2 index decode
    be = 1'b1; long_load(4'd3, 32'h1111_2222, 32'h3333_4444);
    chk("R3 big endian layout", mdl[3], 64'h1111_2222_3333_4444);
    long_store(4'd3, "R4 big endian store");
    be = 1'b0; long_load(4'd9, 32'hAAAA_0001, 32'hBBBB_0002);
    be = 1'b1; long_store(4'd9, "R3 little endian load order");
    be = 1'b0; long_store(4'd3, "R4 little endian store order");
    long_store(4'd0, "R2 other index untouched");

    // R7 R8 R10 short loads
    fint = 1'b0; short_load(4'd3, 32'hCAFE_F00D);
    be = 1'b1; long_store(4'd3, "R7 float upper only");
    fint = 1'b1; short_load(4'd5, 32'h8000_0007);
    long_store(4'd5, "R8 sign extend negative");
    short_load(4'd6, 32'h7FFF_FFFF);
    long_store(4'd6, "R8 sign extend positive");
    fint = 1'b0; short_store(4'd5); fint = 1'b1; short_store(4'd5);

    // R6 abort after first beat, then fresh long transfer starts at beat 0
    be = 1'b1;
    do_beat(1'b0, mk_instr(4'd7, 1'b1), 32'h0BAD_0001, 1'b0, rd, p);
    chk("R5 lone first beat inc", 64'(p), 64'b10);
    mdl[7][63:32] = 32'h0BAD_0001;
    do_setup("R6 setup done");
    long_store(4'd7, "R10 lower half kept after abort");
    // setup together with a beat: beat dropped
    do_beat(1'b0, mk_instr(4'd7, 1'b1), 32'hDEAD_DEAD, 1'b1, rd, p);
    chk("R6 setup wins over beat", 64'(p), 64'b01);
    long_store(4'd7, "R6 dropped beat wrote nothing");
    // first beat, then setup+beat, then a full transfer must restart
    do_beat(1'b0, mk_instr(4'd8, 1'b1), 32'h1234_5678, 1'b0, rd, p);
    mdl[8][63:32] = 32'h1234_5678;
    do_beat(1'b0, mk_instr(4'd8, 1'b1), 32'hFFFF_0000, 1'b1, rd, p);
    chk("R6 setup mid transfer", 64'(p), 64'b01);
    be = 1'b0; long_load(4'd8, 32'h0000_00AA, 32'h0000_00BB);
    long_store(4'd8, "R6 restart at first half");
    // R10 long ignores format
    fint = 1'b1; be = 1'b1; long_load(4'd10, 32'h8765_4321, 32'h0F0F_0F0F);
    fint = 1'b0; long_store(4'd10, "R10 long ignores format");

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] idx = 4'($urandom_range(0, 15));
      be = 1'($urandom()); fint = 1'($urandom());
      case ($urandom_range(0, 4))
        0: long_load(idx, $urandom(), $urandom());
        1: long_store(idx, "R4 random long store");
        2: short_load(idx, $urandom());
        3: short_store(idx);
        default: do_setup("R6 random setup");
      endcase
    end
    be = 1'b1;
    for (int i = 0; i < 16; i++) long_store(4'(i), "R10 final file contents");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule